// File: doc/BRIEF.md
# Endpoint Buffer DMA Channel

This block is one DMA channel that copies a buffer from system memory into the bank buffer of a device-to-host endpoint. It needs no processor help once started. Software first loads a start address and a byte count while the channel is idle, then raises the channel enable. From then on the channel reads memory one beat at a time. A beat is `DATA_W/8` bytes wide, or fewer on the final beat. Each beat read is written into the endpoint. The channel decrements the remaining count and stops by itself when the count reaches zero.

At buffer end the channel can do two things, each under its own enable. It can pulse an interrupt. It can also tell the endpoint to validate the current bank, even when that bank is only partly filled. The channel stalls while the endpoint reports no free bank. Clearing the enable pauses the channel and leaves the address and count visible, so raising the enable again resumes the transfer. The channel refuses to start when the endpoint is of control type.

Top module: `ep_dma_chan`

## Requirements
- R1: A `cfg_load` pulse while the channel is idle makes `sts_addr` equal `cfg_addr` and `sts_remain` equal `cfg_size` from the next cycle on. A `cfg_load` pulse while `sts_busy` is high changes nothing.
- R2: A rising `cfg_en` with a nonzero remaining count and `ep_is_ctrl` low sets `sts_busy` on the next clock edge.
- R3: Each cycle with `mem_req` and `mem_gnt` both high is one beat. On the next cycle `ep_wr_en` is high for one cycle, `ep_wr_data` holds the `mem_rdata` of the beat, and `ep_wr_bytes` equals min(`DATA_W/8`, remaining count). In the same cycle `sts_addr` has risen by `DATA_W/8` and `sts_remain` has fallen by `ep_wr_bytes`.
- R4: `mem_req` is never high while `ep_bank_free` is low. The transfer resumes once a bank is free.
- R5: After the beat that brings the count to zero, `sts_busy` is low and no further `mem_req` is raised.
- R6: `irq` pulses for exactly one cycle, together with the final `ep_wr_en`, when `cfg_end_irq_en` is set. It stays low otherwise.
- R7: `ep_validate` pulses for exactly one cycle, together with the final `ep_wr_en`, when `cfg_end_val_en` is set. It stays low otherwise.
- R8: Dropping `cfg_en` while busy lowers `mem_req` at once and clears `sts_busy` on the next edge. No beat follows, and `sts_addr` and `sts_remain` hold. A new rising `cfg_en` resumes from there.
- R9: Starting with a remaining count of zero raises no `mem_req`. In the cycle after the start edge, `irq` and `ep_validate` pulse as their enables select.
- R10: With `ep_is_ctrl` high, a rising `cfg_en` is ignored: `sts_busy`, `mem_req`, `irq` and `ep_validate` stay low and the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr | input | ADDR_W | Buffer start byte address, loaded by `cfg_load` |
| cfg_size | input | CNT_W | Buffer byte count, loaded by `cfg_load` |
| cfg_load | input | 1 | Load strobe for address and count (idle only) |
| cfg_en | input | 1 | Channel enable; a rising edge starts or resumes |
| cfg_end_val_en | input | 1 | Validate the bank at buffer end |
| cfg_end_irq_en | input | 1 | Raise `irq` at buffer end |
| ep_is_ctrl | input | 1 | Endpoint is control type; blocks starting |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read byte address |
| mem_gnt | input | 1 | Read granted; `mem_rdata` valid in the same cycle |
| mem_rdata | input | DATA_W | Memory read data |
| ep_bank_free | input | 1 | Endpoint has a free bank |
| ep_wr_en | output | 1 | Endpoint write strobe |
| ep_wr_data | output | DATA_W | Endpoint write data |
| ep_wr_bytes | output | $clog2(DATA_W/8+1) | Valid bytes in the write |
| ep_validate | output | 1 | Validate-current-bank pulse |
| sts_busy | output | 1 | Channel running |
| sts_addr | output | ADDR_W | Current read address |
| sts_remain | output | CNT_W | Bytes still to send |
| irq | output | 1 | End-of-buffer interrupt pulse |

## Verification
`mem_req` is combinational from state, `cfg_en` and `ep_bank_free`, so it is sampled in the same cycle as the inputs that gate it. Every other result is registered. Beat data, byte count, address, count, `irq` and `ep_validate` are all due one cycle after the edge that took the grant. `sts_busy` changes one edge after the enable changes, and a zero-size start pulses on the first cycle after the start edge. The bench drives and samples only at falling edges. It first takes the outputs the last rising edge produced, then drives the next stimulus, so each expected value is compared exactly one register stage after its cause.

// File: rtl/ep_dma_pkg.sv
package ep_dma_pkg;
   typedef enum logic {
      CH_IDLE = 1'b0,
      CH_RUN  = 1'b1
   } ch_state_e;
endpackage

// File: rtl/ep_dma_dp.sv
module ep_dma_dp #(
   parameter int ADDR_W     = 16,
   parameter int CNT_W      = 8,
   parameter int BEAT_BYTES = 4,
   parameter int BYTES_W    = $clog2(BEAT_BYTES + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [ADDR_W-1:0]  load_addr,
   input  logic [CNT_W-1:0]   load_size,
   input  logic               step,
   output logic [ADDR_W-1:0]  addr,
   output logic [CNT_W-1:0]   remain,
   output logic [BYTES_W-1:0] beat_bytes,
   output logic               last_beat,
   output logic               empty
);
   localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(BEAT_BYTES);
   localparam logic [CNT_W-1:0]  CNT_BEAT  = CNT_W'(BEAT_BYTES);

   generate
      if (BEAT_BYTES == 1) begin : g_byte
         assign beat_bytes = BYTES_W'(1);
         assign last_beat  = (remain == CNT_W'(1));
      end else begin : g_word
         assign beat_bytes = (remain < CNT_BEAT) ? remain[BYTES_W-1:0]
                                                 : BYTES_W'(BEAT_BYTES);
         assign last_beat  = (remain <= CNT_BEAT);
      end
   endgenerate

   assign empty = (remain == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr   <= '0;
         remain <= '0;
      end else if (load) begin
         addr   <= load_addr;
         remain <= load_size;
      end else if (step) begin
         addr   <= addr + ADDR_STEP;
         remain <= remain - CNT_W'(beat_bytes);
      end
   end
endmodule

// File: rtl/ep_dma_ctrl.sv
module ep_dma_ctrl
   import ep_dma_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_en,
   input  logic ep_is_ctrl,
   input  logic bank_free,
   input  logic gnt,
   input  logic empty,
   input  logic last_beat,
   input  logic irq_en,
   input  logic val_en,
   output logic busy,
   output logic req,
   output logic step,
   output logic load_ok,
   output logic irq,
   output logic validate
);
   ch_state_e state_q, state_d;
   logic      en_q;
   logic      start;
   logic      done;

   assign start   = cfg_en && !en_q && !ep_is_ctrl && (state_q == CH_IDLE);
   assign busy    = (state_q == CH_RUN);
   assign req     = busy && cfg_en && bank_free;
   assign step    = req && gnt;
   assign load_ok = (state_q == CH_IDLE);
   assign done    = (start && empty) || (step && last_beat);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         CH_IDLE: if (start && !empty) state_d = CH_RUN;
         CH_RUN: begin
            if (!cfg_en)                state_d = CH_IDLE;
            else if (step && last_beat) state_d = CH_IDLE;
         end
         default: state_d = CH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= CH_IDLE;
         en_q     <= 1'b0;
         irq      <= 1'b0;
         validate <= 1'b0;
      end else begin
         state_q  <= state_d;
         en_q     <= cfg_en;
         irq      <= done && irq_en;
         validate <= done && val_en;
      end
   end
endmodule

// File: rtl/ep_dma_chan.sv
module ep_dma_chan #(
   parameter int ADDR_W  = 16,
   parameter int CNT_W   = 8,
   parameter int DATA_W  = 32,
   parameter int BYTES_W = $clog2(DATA_W/8 + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  cfg_addr,
   input  logic [CNT_W-1:0]   cfg_size,
   input  logic               cfg_load,
   input  logic               cfg_en,
   input  logic               cfg_end_val_en,
   input  logic               cfg_end_irq_en,
   input  logic               ep_is_ctrl,
   output logic               mem_req,
   output logic [ADDR_W-1:0]  mem_addr,
   input  logic               mem_gnt,
   input  logic [DATA_W-1:0]  mem_rdata,
   input  logic               ep_bank_free,
   output logic               ep_wr_en,
   output logic [DATA_W-1:0]  ep_wr_data,
   output logic [BYTES_W-1:0] ep_wr_bytes,
   output logic               ep_validate,
   output logic               sts_busy,
   output logic [ADDR_W-1:0]  sts_addr,
   output logic [CNT_W-1:0]   sts_remain,
   output logic               irq
);
   localparam int BEAT_BYTES = DATA_W / 8;

   generate
      if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_data
         $error("DATA_W must be a nonzero multiple of 8");
      end
      if ((BEAT_BYTES & (BEAT_BYTES - 1)) != 0) begin : g_bad_beat
         $error("DATA_W/8 must be a power of two");
      end
      if (CNT_W <= BYTES_W) begin : g_bad_cnt
         $error("CNT_W must exceed the beat byte-count width");
      end
      if (BYTES_W != $clog2(BEAT_BYTES + 1)) begin : g_bad_bw
         $error("BYTES_W must not be overridden");
      end
   endgenerate

   logic               load_ok, step, last_beat, empty;
   logic [BYTES_W-1:0] beat_bytes;

   ep_dma_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_en    (cfg_en),
      .ep_is_ctrl(ep_is_ctrl),
      .bank_free (ep_bank_free),
      .gnt       (mem_gnt),
      .empty     (empty),
      .last_beat (last_beat),
      .irq_en    (cfg_end_irq_en),
      .val_en    (cfg_end_val_en),
      .busy      (sts_busy),
      .req       (mem_req),
      .step      (step),
      .load_ok   (load_ok),
      .irq       (irq),
      .validate  (ep_validate)
   );

   ep_dma_dp #(
      .ADDR_W    (ADDR_W),
      .CNT_W     (CNT_W),
      .BEAT_BYTES(BEAT_BYTES),
      .BYTES_W   (BYTES_W)
   ) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (cfg_load && load_ok),
      .load_addr (cfg_addr),
      .load_size (cfg_size),
      .step      (step),
      .addr      (sts_addr),
      .remain    (sts_remain),
      .beat_bytes(beat_bytes),
      .last_beat (last_beat),
      .empty     (empty)
   );

   assign mem_addr = sts_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ep_wr_en    <= 1'b0;
         ep_wr_data  <= '0;
         ep_wr_bytes <= '0;
      end else begin
         ep_wr_en <= step;
         if (step) begin
            ep_wr_data  <= mem_rdata;
            ep_wr_bytes <= beat_bytes;
         end
      end
   end
endmodule

// File: rtl/ep_dma_chan_chk.sv
module ep_dma_chan_chk #(
   parameter int ADDR_W  = 16,
   parameter int CNT_W   = 8,
   parameter int DATA_W  = 32,
   parameter int BYTES_W = $clog2(DATA_W/8 + 1)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_load,
   input logic               cfg_en,
   input logic               cfg_end_irq_en,
   input logic               ep_is_ctrl,
   input logic               mem_req,
   input logic               mem_gnt,
   input logic               ep_bank_free,
   input logic               ep_wr_en,
   input logic               sts_busy,
   input logic [ADDR_W-1:0]  sts_addr,
   input logic [CNT_W-1:0]   sts_remain,
   input logic               irq
);
   localparam int BEAT = DATA_W / 8;

   AST_REQ_NEEDS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ep_bank_free); // R4
   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !sts_busy |-> !mem_req); // R5
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_gnt) |=> (ep_wr_en && sts_addr == $past(sts_addr) + ADDR_W'(BEAT))); // R3
   AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_gnt && sts_remain > CNT_W'(BEAT)) |=> (sts_remain == $past(sts_remain) - CNT_W'(BEAT))); // R3
   AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (sts_remain == '0 && !sts_busy)); // R6
   AST_STOP_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_busy && !cfg_en) |=> (!sts_busy && $stable(sts_remain) && $stable(sts_addr))); // R8
   AST_CTRL_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (ep_is_ctrl && !sts_busy) |=> !sts_busy); // R10
   AST_LOAD_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_busy && cfg_load && !(mem_req && mem_gnt)) |=> $stable(sts_remain)); // R1
   AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq); // R6
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_end_irq_en) |=> !irq); // R6
endmodule

bind ep_dma_chan ep_dma_chan_chk #(
   .ADDR_W (ADDR_W),
   .CNT_W  (CNT_W),
   .DATA_W (DATA_W),
   .BYTES_W(BYTES_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_load      (cfg_load),
   .cfg_en        (cfg_en),
   .cfg_end_irq_en(cfg_end_irq_en),
   .ep_is_ctrl    (ep_is_ctrl),
   .mem_req       (mem_req),
   .mem_gnt       (mem_gnt),
   .ep_bank_free  (ep_bank_free),
   .ep_wr_en      (ep_wr_en),
   .sts_busy      (sts_busy),
   .sts_addr      (sts_addr),
   .sts_remain    (sts_remain),
   .irq           (irq)
);

// File: tb/ep_dma_chan_tb_top.sv
module ep_dma_chan_tb_top;
   localparam int ADDR_W  = 16;
   localparam int CNT_W   = 8;
   localparam int DATA_W  = 32;
   localparam int BYTES_W = 3;
   localparam int BEAT    = 4;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [ADDR_W-1:0]  cfg_addr = '0;
   logic [CNT_W-1:0]   cfg_size = '0;
   logic               cfg_load = 1'b0;
   logic               cfg_en = 1'b0;
   logic               cfg_end_val_en = 1'b0;
   logic               cfg_end_irq_en = 1'b0;
   logic               ep_is_ctrl = 1'b0;
   logic               mem_req;
   logic [ADDR_W-1:0]  mem_addr;
   logic               mem_gnt = 1'b0;
   logic [DATA_W-1:0]  mem_rdata;
   logic               ep_bank_free = 1'b0;
   logic               ep_wr_en;
   logic [DATA_W-1:0]  ep_wr_data;
   logic [BYTES_W-1:0] ep_wr_bytes;
   logic               ep_validate;
   logic               sts_busy;
   logic [ADDR_W-1:0]  sts_addr;
   logic [CNT_W-1:0]   sts_remain;
   logic               irq;

   int checks = 0;
   int failures = 0;
   logic [7:0] lfsr = 8'hB5;

   always #10 clk = ~clk;

   function automatic logic [DATA_W-1:0] fmem(input logic [ADDR_W-1:0] a);
      return {a ^ 16'hA5C3, a};
   endfunction

   assign mem_rdata = fmem(mem_addr);

   ep_dma_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_size(cfg_size),
      .cfg_load(cfg_load), .cfg_en(cfg_en), .cfg_end_val_en(cfg_end_val_en),
      .cfg_end_irq_en(cfg_end_irq_en), .ep_is_ctrl(ep_is_ctrl),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
      .mem_rdata(mem_rdata), .ep_bank_free(ep_bank_free),
      .ep_wr_en(ep_wr_en), .ep_wr_data(ep_wr_data), .ep_wr_bytes(ep_wr_bytes),
      .ep_validate(ep_validate), .sts_busy(sts_busy), .sts_addr(sts_addr),
      .sts_remain(sts_remain), .irq(irq)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic step_lfsr();
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
   endtask

   task automatic run_xfer(input logic [ADDR_W-1:0] base, input int size,
                           input bit ie, input bit ve, input bit rnd,
                           input int stop_k, input bit load_mid);
      logic [ADDR_W-1:0] exp_addr;
      int exp_rem, exp_b, beats, cyc;
      bit fin, stopped, mid_done, last;
      @(negedge clk);
      cfg_addr = base; cfg_size = CNT_W'(size); cfg_load = 1'b1;
      ep_bank_free = 1'b0; mem_gnt = 1'b0;
      @(negedge clk);
      cfg_load = 1'b0;
      chk(sts_addr == base, "R1 addr load", sts_addr, base);
      chk(int'(sts_remain) == size, "R1 size load", sts_remain, size);
      cfg_end_irq_en = ie; cfg_end_val_en = ve; cfg_en = 1'b1;
      if (size == 0) begin
         @(negedge clk);
         chk(irq == ie, "R9 irq zero", irq, ie);
         chk(ep_validate == ve, "R9 validate zero", ep_validate, ve);
         chk(!sts_busy && !mem_req, "R9 no run", {sts_busy, mem_req}, 0);
         @(negedge clk);
         chk(!irq && !ep_validate, "R9 single pulse", {irq, ep_validate}, 0);
         cfg_en = 1'b0;
         return;
      end
      exp_addr = base; exp_rem = size; beats = 0; cyc = 0;
      fin = 0; stopped = 0; mid_done = 0;
      while (!fin && cyc < 400) begin
         @(negedge clk);
         cyc++;
         cfg_load = 1'b0;
         if (cyc == 1) chk(sts_busy, "R2 busy after start", sts_busy, 1);
         if (mem_req) chk(ep_bank_free, "R4 req without bank", ep_bank_free, 1);
         if (ep_wr_en) begin
            exp_b = (exp_rem < BEAT) ? exp_rem : BEAT;
            chk(ep_wr_data == fmem(exp_addr), "R3 data", ep_wr_data, fmem(exp_addr));
            chk(int'(ep_wr_bytes) == exp_b, "R3 bytes", ep_wr_bytes, exp_b);
            exp_addr = exp_addr + ADDR_W'(BEAT);
            exp_rem  = exp_rem - exp_b;
            beats++;
            last = (exp_rem == 0);
            chk(irq == (last && ie), "R6 irq timing", irq, last && ie);
            chk(ep_validate == (last && ve), "R7 validate timing", ep_validate, last && ve);
            if (last) fin = 1;
         end else begin
            chk(!irq && !ep_validate, "R6 R7 idle pulse", {irq, ep_validate}, 0);
         end
         chk(sts_addr == exp_addr && int'(sts_remain) == exp_rem, "R1 R3 status",
             {sts_addr, sts_remain}, {exp_addr, CNT_W'(exp_rem)});
         if (fin) break;
         if (stop_k > 0 && !stopped && beats == stop_k) begin
            stopped = 1;
            cfg_en = 1'b0;
            ep_bank_free = 1'b1; mem_gnt = 1'b1;
            @(negedge clk);
            chk(!sts_busy && !mem_req && !ep_wr_en, "R8 stopped",
                {sts_busy, mem_req, ep_wr_en}, 0);
            repeat (3) @(negedge clk);
            chk(sts_addr == exp_addr && int'(sts_remain) == exp_rem, "R8 hold",
                {sts_addr, sts_remain}, {exp_addr, CNT_W'(exp_rem)});
            cfg_en = 1'b1;
            cyc = 0;
            continue;
         end
         if (load_mid && !mid_done && beats == 1) begin
            mid_done = 1;
            cfg_addr = 16'hFFF0; cfg_size = 8'd200; cfg_load = 1'b1;
         end
         ep_bank_free = rnd ? (lfsr[0] | lfsr[2]) : 1'b1;
         mem_gnt      = rnd ? (lfsr[1] | lfsr[3]) : 1'b1;
         step_lfsr();
      end
      if (!fin) chk(0, "R5 watchdog", cyc, 0);
      ep_bank_free = 1'b1; mem_gnt = 1'b1;
      @(negedge clk);
      chk(!sts_busy && !mem_req && !irq && !ep_wr_en, "R5 ended",
          {sts_busy, mem_req, irq, ep_wr_en}, 0);
      cfg_en = 1'b0;
      @(negedge clk);
      chk(!mem_req, "R5 no req after end", mem_req, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!sts_busy && !mem_req && !irq && !ep_wr_en && !ep_validate && sts_remain == 0,
          "R5 reset state", {sts_busy, mem_req, irq, ep_wr_en, ep_validate}, 0);
      for (int sz = 0; sz < 24; sz++) begin
         for (int m = 0; m < 4; m++) begin
            run_xfer(ADDR_W'(16'h0100 + 64 * sz), sz, m[0], m[1], (sz % 2) == 1, 0, 0);
         end
      end
      run_xfer(16'h2000, 16, 1, 1, 0, 2, 0);
      run_xfer(16'h2100, 23, 1, 0, 1, 3, 0);
      run_xfer(16'h3000, 20, 0, 1, 0, 0, 1);
      run_xfer(16'h3100, 255, 1, 1, 1, 0, 1);
      // R10: control endpoint blocks start
      @(negedge clk);
      ep_is_ctrl = 1'b1; cfg_addr = 16'h4000; cfg_size = 8'd12; cfg_load = 1'b1;
      cfg_end_irq_en = 1'b1; cfg_end_val_en = 1'b1; ep_bank_free = 1'b1; mem_gnt = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0; cfg_en = 1'b1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk(!sts_busy && !mem_req && !irq && !ep_validate && sts_remain == 8'd12,
             "R10 control ignored", {sts_busy, mem_req, irq, ep_validate}, 0);
      end
      cfg_en = 1'b0; ep_is_ctrl = 1'b0;
      @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL R5 global watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule